// File: doc/BRIEF.md
# Eight-Input Programmable Interrupt Controller

This block is a programmable interrupt controller for eight request inputs. Software reaches it through a byte-wide register port. The port has a one-bit port select (command or data), a write strobe, a read strobe and a combinational read-data bus. Requests arrive already conditioned as one-cycle set pulses. A separate level vector reports which inputs are still active. The block keeps request, in-service and mask registers, a vector base and a rotating lowest-priority pointer. A priority resolver picks the highest eligible request. When there is one, the block raises a single interrupt line and shows the matching vector.

Software brings the block up with a four-word initialization sequence, which includes mode checks. After that it drives the block with three operation commands. The mask command loads the mask register. The end-of-service command handles specific or non-specific end of service, rotation and priority setting. The mode command covers special mask mode, register-read selection and a one-shot poll. The processor side reports an accepted pin on an acknowledge input. A poll read accepts a pin through the register port instead. The parameter `IS_MASTER` decides whether the fully nested override for the cascade pin exists.

Top module: `pic8_ctrl`

## Requirements
- R1: After reset the block is not ready. The request, in-service and mask registers, the vector base and the lowest-priority pointer are zero, the interrupt output is low, and the vector output shows base plus 7 (0x07).
- R2: A command-port write with bit 4 set starts initialization. It clears the request and mask registers, sets the lowest-priority pointer to 7, clears the poll, special-mask and read-select flags, and makes the block not ready. If bit 1 (single) is set or bit 0 (fourth word needed) is clear, the sequence stays at its first step, so the next data write loads the mask.
- R3: After an accepted first word, the next data write stores bits 7:3 as the vector base, and the following data write is ignored. The vector output is {base, pin} for the top eligible pin, or {base, 7} when no pin is eligible.
- R4: The fourth data write is accepted only if its bit 0 is set. An accepted word sets auto-end mode from bit 1 and, when IS_MASTER=1, nested mode from bit 4, then makes the block ready. A rejected word leaves the block not ready and waiting for the fourth word. In nested mode, an in-service cascade pin (CASC_PIN) does not block new requests on that pin.
- R5: Once the sequence is complete, a data write loads the mask register, and a data read returns it. A masked request is neither raised nor shown on the vector output.
- R6: Priority runs from pin (lowest+1) mod 8 upward with wrap. An in-service pin blocks itself and every lower-priority pin from being chosen.
- R7: The interrupt output rises one cycle after a ready block has an eligible request. It then stays high until an accept, whatever the request and mask registers do. It never rises while the block is not ready.
- R8: An accept (acknowledge input or poll read) drops the interrupt output on the next cycle. It sets the pin's in-service bit. It clears the pin's request bit unless the pin's level input is active.
- R9: In auto-end mode an accept leaves the in-service register unchanged. If the rotate flag is set, the accepted pin becomes the lowest-priority pin.
- R10: A ready command write with bits 4 and 3 clear is an end-of-service command. Bit 7 latches the rotate flag. With bit 5 set, it clears the in-service bit of pin bits 2:0 if bit 6 is set, otherwise of the highest-priority in-service pin, and with rotate that pin becomes lowest. With bit 5 clear and bits 6 and 7 set, bits 2:0 load the lowest-priority pointer.
- R11: A ready command write with bit 4 clear and bit 3 set is a mode command. Bit 5 sets special mask mode only when bit 6 is set. Bit 0 selects the read source (1 = in-service, 0 = request) only when bit 1 is set. Bit 2 arms a poll. A command read returns the selected register.
- R12: A command read with a poll armed disarms it. If a request is eligible, it accepts that pin and returns 0x80 OR pin. Otherwise it returns 0x00 and accepts nothing.
- R13: In special mask mode, in-service bits do not block requests. A non-specific end of service skips in-service pins that are masked.
- R14: Request pulses are ignored while the block is not ready. A request pulse on the pin being accepted in the same cycle keeps that pin's request bit set.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| port_sel | input | 1 | 0 = command port, 1 = data port |
| wr_en | input | 1 | Register write strobe |
| rd_en | input | 1 | Register read strobe (side effect only for poll) |
| wr_data | input | 8 | Write data |
| rd_data | output | 8 | Read data for the current port select |
| req_set | input | 8 | One-cycle request pulses per pin |
| req_held | input | 8 | Request inputs still active |
| ack_valid | input | 1 | Interrupt acknowledge strobe |
| ack_pin | input | 3 | Pin being acknowledged |
| intr_out | output | 1 | Interrupt request to the processor |
| vec_out | output | 8 | Vector for the current top eligible pin |

## Verification
An accept and a fresh request on the same pin can land in the same cycle. In that case the request must win and the request bit must survive. The bench drives an acknowledge together with a set pulse for that pin and then reads the request register through the command port. Random rounds load masks, request patterns and priority pointers. Each round compares the vector and interrupt line against a bench priority function, then acknowledges and ends service. Directed sequences cover rotation, poll, special mask, auto-end and nested mode.

// File: rtl/pic8_pkg.sv
package pic8_pkg;

   typedef enum logic [1:0] {
      SEQ_W1,
      SEQ_W2,
      SEQ_W3,
      SEQ_W4
   } seq_e;

   typedef enum logic [2:0] {
      WR_NONE,
      WR_INIT1,
      WR_INIT2,
      WR_INIT3,
      WR_INIT4,
      WR_MASK,
      WR_EOS,
      WR_MODE
   } wr_kind_e;

   // command-port decode bits
   localparam int B_INIT_SEL  = 4;
   localparam int B_MODE_SEL  = 3;
   // first init word
   localparam int B_I1_NEED4  = 0;
   localparam int B_I1_SINGLE = 1;
   // fourth init word
   localparam int B_I4_CPU    = 0;
   localparam int B_I4_AUTO   = 1;
   localparam int B_I4_NEST   = 4;
   // end-of-service command
   localparam int B_ES_ROT    = 7;
   localparam int B_ES_SPEC   = 6;
   localparam int B_ES_EOI    = 5;
   // mode command
   localparam int B_MD_SMM_EN = 6;
   localparam int B_MD_SMM    = 5;
   localparam int B_MD_POLL   = 2;
   localparam int B_MD_RD_EN  = 1;
   localparam int B_MD_RD_ISR = 0;

endpackage

// File: rtl/pic8_decode.sv
module pic8_decode
   import pic8_pkg::*;
(
   input  logic     wr_en,
   input  logic     port_sel,
   input  logic     init_bit,
   input  logic     mode_bit,
   input  logic     ready,
   input  seq_e     seq,
   output wr_kind_e kind
);

   always_comb begin
      kind = WR_NONE;
      if (wr_en) begin
         if (!port_sel) begin
            if (init_bit)
               kind = WR_INIT1;
            else if (ready)
               kind = mode_bit ? WR_MODE : WR_EOS;
         end else begin
            unique case (seq)
               SEQ_W2:  kind = WR_INIT2;
               SEQ_W3:  kind = WR_INIT3;
               SEQ_W4:  kind = WR_INIT4;
               default: kind = WR_MASK;
            endcase
         end
      end
   end

endmodule

// File: rtl/pic8_resolver.sv
module pic8_resolver #(
   parameter int PINS     = 8,
   parameter int CASC_PIN = 2
) (
   input  logic [PINS-1:0]         req,
   input  logic [PINS-1:0]         svc,
   input  logic [PINS-1:0]         mask,
   input  logic [$clog2(PINS)-1:0] lowest,
   input  logic                    smm,
   input  logic                    nest,
   output logic                    req_ok,
   output logic [$clog2(PINS)-1:0] req_pin,
   output logic                    svc_ok,
   output logic [$clog2(PINS)-1:0] svc_pin
);

   localparam int PW = $clog2(PINS);
   localparam logic [PINS-1:0] CASC_BIT = PINS'(1) << CASC_PIN;

   if ((1 << PW) != PINS) begin : g_bad_pins
      $error("pic8_resolver: PINS must be a power of two");
   end
   if (CASC_PIN >= PINS) begin : g_bad_casc
      $error("pic8_resolver: CASC_PIN out of range");
   end

   logic [PINS-1:0] blocker;
   assign blocker = smm ? '0 : (nest ? (svc & ~CASC_BIT) : svc);

   always_comb begin : scan_req
      logic          stop;
      logic [PW-1:0] idx;
      stop    = 1'b0;
      idx     = '0;
      req_ok  = 1'b0;
      req_pin = '0;
      for (int k = 0; k < PINS; k++) begin
         idx = PW'(lowest + PW'(1) + PW'(k));
         if (!stop && !req_ok) begin
            if (blocker[idx])
               stop = 1'b1;
            else if (req[idx] && !mask[idx]) begin
               req_ok  = 1'b1;
               req_pin = idx;
            end
         end
      end
   end

   always_comb begin : scan_svc
      logic [PW-1:0] idx;
      idx     = '0;
      svc_ok  = 1'b0;
      svc_pin = '0;
      for (int k = 0; k < PINS; k++) begin
         idx = PW'(lowest + PW'(1) + PW'(k));
         if (!svc_ok && svc[idx] && !(smm && mask[idx])) begin
            svc_ok  = 1'b1;
            svc_pin = idx;
         end
      end
   end

endmodule

// File: rtl/pic8_ctrl.sv
module pic8_ctrl
   import pic8_pkg::*;
#(
   parameter bit IS_MASTER = 1'b1,
   parameter int CASC_PIN  = 2,
   parameter int PINS      = 8
) (
   input  logic                    clk,
   input  logic                    rst_n,
   input  logic                    port_sel,
   input  logic                    wr_en,
   input  logic                    rd_en,
   input  logic [PINS-1:0]         wr_data,
   output logic [PINS-1:0]         rd_data,
   input  logic [PINS-1:0]         req_set,
   input  logic [PINS-1:0]         req_held,
   input  logic                    ack_valid,
   input  logic [$clog2(PINS)-1:0] ack_pin,
   output logic                    intr_out,
   output logic [PINS-1:0]         vec_out
);

   localparam int PW     = $clog2(PINS);
   localparam int DW     = PINS;
   localparam int BASE_W = DW - PW;

   if (PINS != 8) begin : g_bad_width
      $error("pic8_ctrl: the register port is one byte, PINS must be 8");
   end

   logic [PINS-1:0]   irr_q, irr_n, isr_q, isr_n, imr_q, imr_n;
   logic [BASE_W-1:0] base_q, base_n;
   logic [PW-1:0]     low_q, low_n;
   seq_e              seq_q, seq_n;
   logic              ready_q, ready_n, auto_q, auto_n, rot_q, rot_n;
   logic              poll_q, poll_n, rdsel_q, rdsel_n, smm_q, smm_n;
   logic              raised_q, raised_n;
   logic              nest;

   wr_kind_e          kind;
   logic              req_ok, svc_ok;
   logic [PW-1:0]     req_pin, svc_pin;

   pic8_decode u_decode (
      .wr_en    (wr_en),
      .port_sel (port_sel),
      .init_bit (wr_data[B_INIT_SEL]),
      .mode_bit (wr_data[B_MODE_SEL]),
      .ready    (ready_q),
      .seq      (seq_q),
      .kind     (kind)
   );

   pic8_resolver #(.PINS(PINS), .CASC_PIN(CASC_PIN)) u_resolver (
      .req     (irr_q),
      .svc     (isr_q),
      .mask    (imr_q),
      .lowest  (low_q),
      .smm     (smm_q),
      .nest    (nest),
      .req_ok  (req_ok),
      .req_pin (req_pin),
      .svc_ok  (svc_ok),
      .svc_pin (svc_pin)
   );

   // nested-mode flag exists only in the master variant
   if (IS_MASTER) begin : g_nest
      logic nest_q;
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n)
            nest_q <= 1'b0;
         else if (kind == WR_INIT4 && wr_data[B_I4_CPU])
            nest_q <= wr_data[B_I4_NEST];
      end
      assign nest = nest_q;
   end else begin : g_flat
      assign nest = 1'b0;
   end

   logic          poll_rd, acc_go;
   logic [PW-1:0] acc_pin;

   assign poll_rd = rd_en && !port_sel && poll_q;
   assign acc_go  = (poll_rd && req_ok) || ack_valid;
   assign acc_pin = (poll_rd && req_ok) ? req_pin : ack_pin;

   always_comb begin
      logic [PW-1:0] eos_pin;
      logic          eos_ok;
      irr_n    = irr_q;
      isr_n    = isr_q;
      imr_n    = imr_q;
      base_n   = base_q;
      low_n    = low_q;
      seq_n    = seq_q;
      ready_n  = ready_q;
      auto_n   = auto_q;
      rot_n    = rot_q;
      poll_n   = poll_q;
      rdsel_n  = rdsel_q;
      smm_n    = smm_q;
      raised_n = raised_q;
      eos_pin  = wr_data[B_ES_SPEC] ? wr_data[PW-1:0] : svc_pin;
      eos_ok   = wr_data[B_ES_SPEC] || svc_ok;

      if (poll_rd)
         poll_n = 1'b0;

      unique case (kind)
         WR_INIT1: begin
            irr_n   = '0;
            imr_n   = '0;
            low_n   = PW'(PINS - 1);
            poll_n  = 1'b0;
            smm_n   = 1'b0;
            rdsel_n = 1'b0;
            ready_n = 1'b0;
            seq_n   = (wr_data[B_I1_SINGLE] || !wr_data[B_I1_NEED4]) ? SEQ_W1 : SEQ_W2;
         end
         WR_INIT2: begin
            base_n = wr_data[DW-1 -: BASE_W];
            seq_n  = SEQ_W3;
         end
         WR_INIT3: seq_n = SEQ_W4;
         WR_INIT4: begin
            if (wr_data[B_I4_CPU]) begin
               auto_n  = wr_data[B_I4_AUTO];
               ready_n = 1'b1;
               seq_n   = SEQ_W1;
            end
         end
         WR_MASK: imr_n = wr_data;
         WR_EOS: begin
            rot_n = wr_data[B_ES_ROT];
            if (wr_data[B_ES_EOI]) begin
               if (eos_ok) begin
                  isr_n[eos_pin] = 1'b0;
                  if (wr_data[B_ES_ROT])
                     low_n = eos_pin;
               end
            end else if (wr_data[B_ES_SPEC] && wr_data[B_ES_ROT]) begin
               low_n = wr_data[PW-1:0];
            end
         end
         WR_MODE: begin
            if (wr_data[B_MD_SMM_EN])
               smm_n = wr_data[B_MD_SMM];
            if (wr_data[B_MD_RD_EN])
               rdsel_n = wr_data[B_MD_RD_ISR];
            if (wr_data[B_MD_POLL])
               poll_n = 1'b1;
         end
         default: ;
      endcase

      if (acc_go) begin
         raised_n = 1'b0;
         if (!req_held[acc_pin])
            irr_n[acc_pin] = 1'b0;
         if (auto_q) begin
            if (rot_q)
               low_n = acc_pin;
         end else begin
            isr_n[acc_pin] = 1'b1;
         end
      end else if (ready_q && !raised_q && req_ok) begin
         raised_n = 1'b1;
      end

      if (ready_q && kind != WR_INIT1)
         irr_n = irr_n | req_set;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         irr_q    <= '0;
         isr_q    <= '0;
         imr_q    <= '0;
         base_q   <= '0;
         low_q    <= '0;
         seq_q    <= SEQ_W1;
         ready_q  <= 1'b0;
         auto_q   <= 1'b0;
         rot_q    <= 1'b0;
         poll_q   <= 1'b0;
         rdsel_q  <= 1'b0;
         smm_q    <= 1'b0;
         raised_q <= 1'b0;
      end else begin
         irr_q    <= irr_n;
         isr_q    <= isr_n;
         imr_q    <= imr_n;
         base_q   <= base_n;
         low_q    <= low_n;
         seq_q    <= seq_n;
         ready_q  <= ready_n;
         auto_q   <= auto_n;
         rot_q    <= rot_n;
         poll_q   <= poll_n;
         rdsel_q  <= rdsel_n;
         smm_q    <= smm_n;
         raised_q <= raised_n;
      end
   end

   assign intr_out = raised_q;
   assign vec_out  = {base_q, req_ok ? req_pin : PW'(PINS - 1)};

   always_comb begin
      if (!port_sel && poll_q)
         rd_data = req_ok ? {1'b1, {(DW-1-PW){1'b0}}, req_pin} : '0;
      else if (port_sel)
         rd_data = imr_q;
      else
         rd_data = rdsel_q ? isr_q : irr_q;
   end

   // R7: a rise of the interrupt line needs a ready block
   p_raise_ready_r7: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(intr_out) |-> $past(ready_q));

   // R8: an acknowledge drops the line next cycle
   p_ack_drops_r8: assert property (@(posedge clk) disable iff (!rst_n)
      ack_valid |=> !intr_out);

   // R9: auto-end accepts leave the in-service register alone
   p_auto_isr_r9: assert property (@(posedge clk) disable iff (!rst_n)
      (ack_valid && auto_q && !wr_en) |=> $stable(isr_q));

   // R2: first init word clears and drops ready
   p_init1_clear_r2: assert property (@(posedge clk) disable iff (!rst_n)
      (wr_en && !port_sel && wr_data[B_INIT_SEL]) |=> (!ready_q && imr_q == '0 && irr_q == '0));

   // R14: no new request bits while not ready
   p_idle_irr_r14: assert property (@(posedge clk) disable iff (!rst_n)
      (!ready_q && !ack_valid && !rd_en) |=> ((irr_q & ~$past(irr_q)) == '0));

   // R5: a ready data write loads the mask
   p_mask_load_r5: assert property (@(posedge clk) disable iff (!rst_n)
      (ready_q && wr_en && port_sel) |=> (imr_q == $past(wr_data)));

endmodule

// File: tb/pic8_ctrl_tb.sv
module pic8_ctrl_tb;

   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic       port_sel = 1'b0;
   logic       wr_en = 1'b0;
   logic       rd_en = 1'b0;
   logic [7:0] wr_data = '0;
   logic [7:0] rd_data;
   logic [7:0] req_set = '0;
   logic [7:0] req_held = '0;
   logic       ack_valid = 1'b0;
   logic [2:0] ack_pin = '0;
   logic       intr_out;
   logic [7:0] vec_out;

   int n_chk = 0;
   int n_fail = 0;

   always #5 clk = ~clk;

   pic8_ctrl u_dut (
      .clk(clk), .rst_n(rst_n), .port_sel(port_sel), .wr_en(wr_en), .rd_en(rd_en),
      .wr_data(wr_data), .rd_data(rd_data), .req_set(req_set), .req_held(req_held),
      .ack_valid(ack_valid), .ack_pin(ack_pin), .intr_out(intr_out), .vec_out(vec_out)
   );

   task automatic chk(input string tag, input logic [7:0] got, input logic [7:0] exp);
      n_chk++;
      if (got !== exp) begin
         n_fail++;
         $display("FAIL %s: got 0x%02h expected 0x%02h", tag, got, exp);
      end
   endtask

   task automatic step();
      @(negedge clk);
   endtask

   task automatic wr(input logic a, input logic [7:0] d);
      @(negedge clk);
      port_sel = a; wr_data = d; wr_en = 1'b1;
      @(negedge clk);
      wr_en = 1'b0;
   endtask

   task automatic rd(input logic a, output logic [7:0] d);
      @(negedge clk);
      port_sel = a; rd_en = 1'b1;
      #1 d = rd_data;
      @(negedge clk);
      rd_en = 1'b0;
   endtask

   task automatic pulse(input logic [7:0] m);
      @(negedge clk);
      req_set = m;
      @(negedge clk);
      req_set = '0;
   endtask

   task automatic ack(input logic [2:0] p);
      @(negedge clk);
      ack_valid = 1'b1; ack_pin = p;
      @(negedge clk);
      ack_valid = 1'b0;
   endtask

   task automatic init(input logic [7:0] base, input logic [7:0] w4);
      wr(1'b0, 8'h11);
      wr(1'b1, base);
      wr(1'b1, 8'h00);
      wr(1'b1, w4);
   endtask

   // priority model from the requirements
   function automatic int exp_pin(logic [7:0] irr, logic [7:0] isr, logic [7:0] imr,
                                  logic [2:0] lp);
      for (int k = 1; k <= 8; k++) begin
         int p;
         p = (lp + k) % 8;
         if (isr[p]) return -1;
         if (irr[p] && !imr[p]) return p;
      end
      return -1;
   endfunction

   initial begin : watchdog
      repeat (100000) @(posedge clk);
      n_fail++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
   end

   initial begin : main
      logic [7:0] d;
      logic [7:0] irr_m;
      void'($urandom(32'd1234));
      repeat (3) @(negedge clk);
      rst_n = 1'b1;

      // R1 reset state
      rd(1'b1, d); chk("R1 mask", d, 8'h00);
      rd(1'b0, d); chk("R1 request", d, 8'h00);
      chk("R1 intr", {7'd0, intr_out}, 8'h00);
      chk("R1 vector", vec_out, 8'h07);
      pulse(8'h01);
      rd(1'b0, d); chk("R14 ignored before ready", d, 8'h00);

      // R2 rejected first words
      wr(1'b0, 8'h10);
      wr(1'b1, 8'h20);
      rd(1'b1, d); chk("R2 no fourth word -> mask", d, 8'h20);
      wr(1'b0, 8'h13);
      rd(1'b1, d); chk("R2 mask cleared", d, 8'h00);
      wr(1'b1, 8'h55);
      rd(1'b1, d); chk("R2 single -> mask", d, 8'h55);

      // R3/R4 sequence with a rejected fourth word
      wr(1'b0, 8'h11);
      wr(1'b1, 8'h47);
      wr(1'b1, 8'h04);
      wr(1'b1, 8'h00);
      pulse(8'h08);
      rd(1'b0, d); chk("R4 rejected word keeps not ready", d, 8'h00);
      wr(1'b1, 8'h01);
      rd(1'b1, d); chk("R4 fourth word not a mask", d, 8'h00);
      chk("R3 base with none pending", vec_out, 8'h47);

      // R6/R7/R8 priority, raise once, accept
      pulse(8'h28); step();
      chk("R7 raised", {7'd0, intr_out}, 8'h01);
      chk("R6 pin3 over pin5", vec_out, 8'h43);
      pulse(8'h01);
      chk("R6 pin0 wins", vec_out, 8'h40);
      chk("R7 still single raise", {7'd0, intr_out}, 8'h01);
      ack(3'd0);
      rd(1'b0, d); chk("R8 request cleared", d, 8'h28);
      step();
      chk("R6 in-service blocks lower", {7'd0, intr_out}, 8'h00);
      chk("R6 vector none", vec_out, 8'h47);
      wr(1'b0, 8'h0B);
      rd(1'b0, d); chk("R11 read in-service", d, 8'h01);
      wr(1'b0, 8'h20); step();
      chk("R10 non-specific end re-raises", {7'd0, intr_out}, 8'h01);
      chk("R10 vector after end", vec_out, 8'h43);

      // R5 mask
      wr(1'b1, 8'h08);
      chk("R5 masked pin skipped", vec_out, 8'h45);
      ack(3'd5); step();
      chk("R5 nothing eligible", {7'd0, intr_out}, 8'h00);
      wr(1'b1, 8'h00); step();
      chk("R5 unmask raises", {7'd0, intr_out}, 8'h01);
      chk("R5 unmask vector", vec_out, 8'h43);
      ack(3'd3);
      wr(1'b0, 8'h65);
      rd(1'b0, d); chk("R10 specific end pin5", d, 8'h08);
      wr(1'b0, 8'h20);

      // R10 rotation and priority set
      pulse(8'h04); step(); ack(3'd2);
      wr(1'b0, 8'hA0);
      pulse(8'h09); step();
      chk("R10 rotate end -> pin3 first", vec_out, 8'h43);
      ack(3'd3);
      wr(1'b0, 8'hE3);
      chk("R10 specific rotate lowest=3", vec_out, 8'h40);
      wr(1'b0, 8'hC0);
      pulse(8'h02);
      chk("R10 set priority lowest=0", vec_out, 8'h41);
      ack(3'd1); ack(3'd0);
      wr(1'b0, 8'h20); wr(1'b0, 8'h20);
      wr(1'b0, 8'hC7); wr(1'b0, 8'h00);
      rd(1'b0, d); chk("R10 all ends done", d, 8'h00);

      // R8 held input keeps request
      wr(1'b0, 8'h0A);
      req_held = 8'h10;
      pulse(8'h10); ack(3'd4);
      rd(1'b0, d); chk("R8 held keeps request", d, 8'h10);
      req_held = 8'h00;
      ack(3'd4); wr(1'b0, 8'h20);
      rd(1'b0, d); chk("R8 released clears", d, 8'h00);

      // R14 same-cycle accept and request
      pulse(8'h40); step();
      @(negedge clk);
      ack_valid = 1'b1; ack_pin = 3'd6; req_set = 8'h40;
      @(negedge clk);
      ack_valid = 1'b0; req_set = 8'h00;
      rd(1'b0, d); chk("R14 request wins over accept", d, 8'h40);
      ack(3'd6); wr(1'b0, 8'h20);

      // R12 poll
      wr(1'b0, 8'h0C);
      pulse(8'h20);
      rd(1'b0, d); chk("R12 poll returns pin", d, 8'h85);
      rd(1'b0, d); chk("R12 poll accepted pin", d, 8'h00);
      wr(1'b0, 8'h20);
      wr(1'b1, 8'h01);
      pulse(8'h01);
      wr(1'b0, 8'h0C);
      rd(1'b0, d); chk("R12 poll empty", d, 8'h00);
      rd(1'b0, d); chk("R12 poll one-shot", d, 8'h01);
      wr(1'b1, 8'h00); step(); ack(3'd0); wr(1'b0, 8'h20);

      // R13 special mask mode
      wr(1'b0, 8'h68);
      pulse(8'h01); step(); ack(3'd0);
      pulse(8'h04); step();
      chk("R13 in-service ignored", {7'd0, intr_out}, 8'h01);
      chk("R13 vector pin2", vec_out, 8'h42);
      wr(1'b1, 8'h01);
      ack(3'd2);
      wr(1'b0, 8'h20);
      wr(1'b0, 8'h0B);
      rd(1'b0, d); chk("R13 end skips masked pin0", d, 8'h01);
      pulse(8'h08); step();
      chk("R11 mode kept without enable bit", vec_out, 8'h43);
      wr(1'b0, 8'h48); wr(1'b1, 8'h00); ack(3'd3);
      wr(1'b0, 8'h20); wr(1'b0, 8'h20);

      // R9 auto-end
      init(8'h88, 8'h03);
      rd(1'b1, d); chk("R2 init clears mask", d, 8'h00);
      wr(1'b0, 8'h80);
      pulse(8'h02); step();
      chk("R9 vector pin1", vec_out, 8'h89);
      ack(3'd1);
      wr(1'b0, 8'h0B);
      rd(1'b0, d); chk("R9 no in-service bit", d, 8'h00);
      pulse(8'h05);
      chk("R9 rotated lowest=1", vec_out, 8'h8A);
      ack(3'd2); ack(3'd0);

      // R4 nested mode
      init(8'h88, 8'h11);
      pulse(8'h04); step(); ack(3'd2);
      pulse(8'h04); step();
      chk("R4 nested cascade not blocked", {7'd0, intr_out}, 8'h01);
      chk("R4 nested vector", vec_out, 8'h8A);
      wr(1'b0, 8'h20);

      // R6 random rounds
      init(8'h20, 8'h01);
      irr_m = '0;
      for (int it = 0; it < 150; it++) begin
         logic [7:0] m, r;
         logic [2:0] lp;
         int p;
         m  = 8'($urandom);
         r  = 8'($urandom);
         lp = 3'($urandom);
         wr(1'b0, 8'hC0 | {5'd0, lp});
         wr(1'b1, m);
         pulse(r);
         irr_m = irr_m | r;
         step();
         p = exp_pin(irr_m, 8'h00, m, lp);
         if (p < 0) begin
            chk("R6 random none", vec_out, 8'h27);
         end else begin
            chk("R6 random vector", vec_out, 8'h20 | 8'(p));
            chk("R7 random raise", {7'd0, intr_out}, 8'h01);
            ack(3'(p));
            irr_m[p] = 1'b0;
            wr(1'b0, 8'h60 | 8'(p));
         end
      end

      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
   end

endmodule